// File: doc/BRIEF.md
# Linked Descriptor Chain Loader

This block walks a linked chain of command descriptors held in memory and hands each one, whole, to a transfer sequencer. A descriptor is eight consecutive 32-bit words. Together they form a complete image of the sequencer's channel register set. The sixth word (slot 5) is the byte address of the next descriptor. Software first writes the chain head into the node register, then pulses `start`. The loader reads the eight words of the head descriptor one at a time, in ascending address order. Once all eight have arrived, it presents the image with a one-cycle `seq_load` strobe and waits for the sequencer to report `seq_done`.

On completion the loader reads the next-node word of the image it just issued. If that word is zero, the chain ends and the loader returns to idle. Any other value starts fetching the next descriptor in the following cycle, without software involvement. A chain whose last next-node word points back at the head therefore runs forever, which suits circular buffers. The first load of a run raises `evt_loaded`, which is distinct from the per-command `evt_cmd_done` pulses. `cancel` abandons the run and pulses `seq_abort` to the sequencer. If a memory read is still in flight when `cancel` arrives, the loader waits for that read to return before it accepts another start.

The controller has six named states:
- IDLE: waiting for a start.
- ISSUE: presents one word read.
- AWAIT: waits for the read data.
- FLUSH: absorbs a read that was abandoned by a cancel.
- LAUNCH: the load strobe.
- RUN: the command executes.

Its transitions are:
- start: IDLE→ISSUE.
- issue: ISSUE→AWAIT.
- word-in: AWAIT→ISSUE.
- last-word: AWAIT→LAUNCH.
- go: LAUNCH→RUN.
- chain: RUN→ISSUE.
- end: RUN→IDLE.
- abort: any active state→IDLE, or to FLUSH when a read is outstanding.
- flushed: FLUSH→IDLE.

Top module: `desc_chain_loader`

## Requirements
- R1: After reset the loader is idle: `busy`, `mem_req`, `seq_load`, `seq_abort`, `evt_loaded` and `evt_cmd_done` are low, and `node_addr` is zero.
- R2: A `head_we` in idle sets `node_addr` to `head_din` one cycle later. A `head_we` while busy has no effect. From the last word of a fetch onward, `node_addr` holds the byte address of the descriptor being loaded or executed.
- R3: A start issues eight single-cycle word reads at byte addresses base, base+4, …, base+28. Each read is issued only after the previous one's data has returned, and the first read appears in the cycle `busy` rises.
- R4: In the cycle after the eighth word returns, `seq_load` is high for exactly one cycle. At that point `seq_image` holds word k verbatim at bits [32k+31:32k].
- R5: `evt_loaded` pulses together with `seq_load` on the first load after a start only, and never on later loads of the same run.
- R6: `seq_done` while executing produces a one-cycle `evt_cmd_done` in the next cycle.
- R7: If the next-node word (slot 5, bits [191:160] of the image) is zero, the loader goes idle in the cycle after `seq_done`.
- R8: If the next-node word is non-zero, the first read of that descriptor is issued in the cycle after `seq_done`.
- R9: A chain whose last next-node word equals the head address keeps loading indefinitely, with `busy` held high.
- R10: `cancel` while busy, with no read outstanding, makes the loader idle one cycle later with a one-cycle `seq_abort` pulse and no `evt_cmd_done`.
- R11: `cancel` while a read is issued and its data has not yet returned keeps `busy` high until that data arrives, then goes idle; `seq_abort` still pulses in the next cycle.
- R12: `start` is ignored while busy and also when `node_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_we | input | 1 | Write chain head into node register (idle only) |
| head_din | input | 32 | Chain head byte address |
| node_addr | output | 32 | Node register: head, or descriptor in progress |
| start | input | 1 | Begin walking the chain |
| cancel | input | 1 | Abandon the run |
| busy | output | 1 | Loader is active |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Byte address of the word read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| seq_load | output | 1 | Image ready for the sequencer (one cycle) |
| seq_image | output | 256 | Eight descriptor words, word k at bits [32k+31:32k] |
| seq_abort | output | 1 | Sequencer must drop its command |
| seq_done | input | 1 | Sequencer finished the command |
| evt_loaded | output | 1 | Chain loaded event (first load of a run) |
| evt_cmd_done | output | 1 | Command completion event |

## Verification
The embedded properties rely on three conditions at the inputs:
- Memory returns at most one `mem_rvalid` per `mem_req`, at least one cycle later.
- The sequencer raises `seq_done` only while executing a command it was given.
- `cancel` is a single-cycle pulse.

The bench's memory model answers exactly one read at a time after a programmable latency. Its sequencer model completes a command a fixed number of cycles after `seq_load`, and it can withhold completion for cancel tests. Cancels are placed at chosen points in the issue, wait and execute phases. Stray `start` and `head_we` pulses are also injected mid-run, and a behavioural model predicts every output cycle by cycle.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_FLUSH,
        ST_LAUNCH,
        ST_RUN
    } dcl_state_e;

    // descriptor shape: number of words and slot of the link word
    localparam int DCL_WORDS     = 8;
    localparam int DCL_LINK_SLOT = 5;
endpackage

// File: rtl/dcl_word_store.sv
module dcl_word_store #(
    parameter int DW = 32,
    parameter int NW = 8,
    localparam int IW = $clog2(NW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    output logic [NW*DW-1:0] image
);
    genvar g;
    generate
        for (g = 0; g < NW; g++) begin : g_word
            logic [DW-1:0] word_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (wr_en && (wr_idx == IW'(g)))
                    word_q <= wr_data;
            end
            assign image[g*DW +: DW] = word_q;
        end
    endgenerate
endmodule

// File: rtl/dcl_ptr_unit.sv
module dcl_ptr_unit #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int NW = 8,
    localparam int IW  = $clog2(NW),
    localparam int BSH = $clog2(DW / 8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_we,
    input  logic [AW-1:0] head_din,
    input  logic          in_idle,
    input  logic          take_head,
    input  logic          take_next,
    input  logic [AW-1:0] next_ptr,
    input  logic          commit_node,
    input  logic          word_clr,
    input  logic          word_inc,
    output logic [IW-1:0] word_idx,
    output logic          last_word,
    output logic [AW-1:0] fetch_addr,
    output logic [AW-1:0] node_addr
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] node_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            node_q <= '0;
            idx_q  <= '0;
        end else begin
            if (take_head)
                base_q <= node_q;
            else if (take_next)
                base_q <= next_ptr;

            if (head_we && in_idle)
                node_q <= head_din;
            else if (commit_node)
                node_q <= base_q;

            if (word_clr)
                idx_q <= '0;
            else if (word_inc)
                idx_q <= idx_q + 1'b1;
        end
    end

    assign word_idx   = idx_q;
    assign last_word  = (idx_q == IW'(NW - 1));
    assign fetch_addr = base_q + (AW'(idx_q) << BSH);
    assign node_addr  = node_q;
endmodule

// File: rtl/dcl_ctrl.sv
module dcl_ctrl
    import dcl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    input  logic mem_rvalid,
    input  logic seq_done,
    input  logic node_nonzero,
    input  logic last_word,
    input  logic next_zero,
    output logic busy,
    output logic mem_req,
    output logic seq_load,
    output logic evt_loaded,
    output logic evt_cmd_done,
    output logic seq_abort,
    output logic in_idle,
    output logic take_head,
    output logic take_next,
    output logic commit_node,
    output logic word_clr,
    output logic word_inc,
    output logic cap_en
);
    dcl_state_e state_q, state_d;
    logic first_q;
    logic done_q;
    logic abort_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start && node_nonzero) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = cancel ? ST_FLUSH : ST_AWAIT;
            ST_AWAIT: begin
                if (cancel)
                    state_d = mem_rvalid ? ST_IDLE : ST_FLUSH;
                else if (mem_rvalid)
                    state_d = last_word ? ST_LAUNCH : ST_ISSUE;
            end
            ST_FLUSH:  if (mem_rvalid) state_d = ST_IDLE;
            ST_LAUNCH: state_d = cancel ? ST_IDLE : ST_RUN;
            ST_RUN: begin
                if (cancel)
                    state_d = ST_IDLE;
                else if (seq_done)
                    state_d = next_zero ? ST_IDLE : ST_ISSUE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        busy        = 1'b1;
        mem_req     = 1'b0;
        seq_load    = 1'b0;
        in_idle     = 1'b0;
        take_head   = 1'b0;
        take_next   = 1'b0;
        commit_node = 1'b0;
        word_inc    = 1'b0;
        cap_en      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                in_idle   = 1'b1;
                take_head = start && node_nonzero;
            end
            ST_ISSUE:  mem_req = 1'b1;
            ST_AWAIT: begin
                cap_en      = mem_rvalid;
                word_inc    = mem_rvalid && !cancel && !last_word;
                commit_node = mem_rvalid && !cancel && last_word;
            end
            ST_FLUSH:  ;
            ST_LAUNCH: seq_load = 1'b1;
            ST_RUN:    take_next = seq_done && !cancel && !next_zero;
            default:   busy = 1'b0;
        endcase
        word_clr = take_head || take_next;
    end

    // event registers and run-first flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            if (take_head)
                first_q <= 1'b1;
            else if (state_q == ST_LAUNCH)
                first_q <= 1'b0;
            done_q  <= (state_q == ST_RUN) && seq_done && !cancel;
            abort_q <= cancel && (state_q != ST_IDLE) && (state_q != ST_FLUSH);
        end
    end

    assign evt_loaded   = (state_q == ST_LAUNCH) && first_q;
    assign evt_cmd_done = done_q;
    assign seq_abort    = abort_q;

    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R3
    fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_req);
    // R4
    load_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_load |-> $past(mem_rvalid));
    // R5
    loaded_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_loaded |-> seq_load);
    // R6
    done_follows_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cmd_done |-> $past(seq_done));
    // R10
    abort_follows_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_abort |-> $past(cancel));
    // R10
    abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_abort |-> !evt_cmd_done);
endmodule

// File: rtl/desc_chain_loader.sv
module desc_chain_loader
    import dcl_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int NW = DCL_WORDS,
    localparam int IW = $clog2(NW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_we,
    input  logic [AW-1:0]    head_din,
    output logic [AW-1:0]    node_addr,
    input  logic             start,
    input  logic             cancel,
    output logic             busy,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic             seq_load,
    output logic [NW*DW-1:0] seq_image,
    output logic             seq_abort,
    input  logic             seq_done,
    output logic             evt_loaded,
    output logic             evt_cmd_done
);
    logic          in_idle, take_head, take_next, commit_node;
    logic          word_clr, word_inc, cap_en, last_word;
    logic [IW-1:0] word_idx;
    logic [AW-1:0] next_ptr;

    assign next_ptr = seq_image[DCL_LINK_SLOT*DW +: AW];

    dcl_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cancel       (cancel),
        .mem_rvalid   (mem_rvalid),
        .seq_done     (seq_done),
        .node_nonzero (node_addr != '0),
        .last_word    (last_word),
        .next_zero    (next_ptr == '0),
        .busy         (busy),
        .mem_req      (mem_req),
        .seq_load     (seq_load),
        .evt_loaded   (evt_loaded),
        .evt_cmd_done (evt_cmd_done),
        .seq_abort    (seq_abort),
        .in_idle      (in_idle),
        .take_head    (take_head),
        .take_next    (take_next),
        .commit_node  (commit_node),
        .word_clr     (word_clr),
        .word_inc     (word_inc),
        .cap_en       (cap_en)
    );

    dcl_ptr_unit #(.AW(AW), .DW(DW), .NW(NW)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_we     (head_we),
        .head_din    (head_din),
        .in_idle     (in_idle),
        .take_head   (take_head),
        .take_next   (take_next),
        .next_ptr    (next_ptr),
        .commit_node (commit_node),
        .word_clr    (word_clr),
        .word_inc    (word_inc),
        .word_idx    (word_idx),
        .last_word   (last_word),
        .fetch_addr  (mem_addr),
        .node_addr   (node_addr)
    );

    dcl_word_store #(.DW(DW), .NW(NW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_en),
        .wr_idx  (word_idx),
        .wr_data (mem_rdata),
        .image   (seq_image)
    );
endmodule

// File: tb/desc_chain_loader_bench.sv
module desc_chain_loader_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         head_we = 1'b0;
    logic [31:0]  head_din = '0;
    logic [31:0]  node_addr;
    logic         start = 1'b0;
    logic         cancel = 1'b0;
    logic         busy;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_rvalid = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic         seq_load;
    logic [255:0] seq_image;
    logic         seq_abort;
    logic         seq_done = 1'b0;
    logic         evt_loaded;
    logic         evt_cmd_done;

    always #5 clk = ~clk;

    desc_chain_loader u_desc_chain_loader (
        .clk(clk), .rst_n(rst_n), .head_we(head_we), .head_din(head_din),
        .node_addr(node_addr), .start(start), .cancel(cancel), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .seq_load(seq_load), .seq_image(seq_image),
        .seq_abort(seq_abort), .seq_done(seq_done), .evt_loaded(evt_loaded),
        .evt_cmd_done(evt_cmd_done)
    );

    int checks = 0;
    int fails = 0;
    int n_loads = 0, n_loaded_evt = 0, n_done_evt = 0;
    int lat = 1;
    int exec_len = 3;
    bit auto_done = 1'b1;
    bit reported = 1'b0;

    logic [31:0] mem [0:511];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
        end
    endtask

    task automatic put_desc(input int base, input int nxt, input int tag);
        for (int k = 0; k < 8; k++)
            mem[(base >> 2) + k] = (k == 5) ? nxt : (32'hA500_0000 | (tag << 8) | k);
    endtask

    // memory model: one outstanding read, fixed latency
    int mem_cd = 0;
    logic [31:0] mem_pend;
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_cd > 0) begin
            mem_cd = mem_cd - 1;
            if (mem_cd == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_pend[10:2]];
            end
        end
        if (mem_req) begin
            mem_cd   = lat;
            mem_pend = mem_addr;
        end
    end

    // sequencer model
    int ex_cd = 0;
    always @(negedge clk) begin
        seq_done <= 1'b0;
        if (ex_cd > 0) begin
            ex_cd = ex_cd - 1;
            if (ex_cd == 0 && auto_done) seq_done <= 1'b1;
        end
        if (seq_load) ex_cd = exec_len;
    end

    // behavioural reference model
    int m_ph = 0, m_idx = 0;
    logic [31:0] m_base = '0, m_node = '0, m_old;
    logic [31:0] m_w [0:7];
    bit m_first = 1'b0, m_abort = 1'b0, m_done = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_base = '0; m_node = '0;
            m_first = 1'b0; m_abort = 1'b0; m_done = 1'b0;
            for (int k = 0; k < 8; k++) m_w[k] = '0;
        end else begin
            m_abort = 1'b0; m_done = 1'b0;
            case (m_ph)
                0: begin
                    m_old = m_node;
                    if (head_we) m_node = head_din;
                    if (start && m_old != 0) begin
                        m_ph = 1; m_base = m_old; m_idx = 0; m_first = 1'b1;
                    end
                end
                1: if (cancel) begin m_ph = 3; m_abort = 1'b1; end else m_ph = 2;
                2: if (cancel) begin
                        m_abort = 1'b1; m_ph = mem_rvalid ? 0 : 3;
                   end else if (mem_rvalid) begin
                        m_w[m_idx] = mem_rdata;
                        if (m_idx == 7) begin m_ph = 4; m_node = m_base; end
                        else begin m_idx++; m_ph = 1; end
                   end
                3: if (mem_rvalid) m_ph = 0;
                4: begin
                    m_first = 1'b0;
                    if (cancel) begin m_ph = 0; m_abort = 1'b1; end else m_ph = 5;
                end
                5: if (cancel) begin m_ph = 0; m_abort = 1'b1; end
                   else if (seq_done) begin
                        m_done = 1'b1;
                        if (m_w[5] == 0) m_ph = 0;
                        else begin m_base = m_w[5]; m_idx = 0; m_ph = 1; end
                   end
                default: m_ph = 0;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [255:0] exp_img;
            for (int k = 0; k < 8; k++) exp_img[k*32 +: 32] = m_w[k];
            chk(busy == (m_ph != 0), "R7", "busy", busy, m_ph != 0);
            chk(mem_req == (m_ph == 1), "R3", "mem_req", mem_req, m_ph == 1);
            if (m_ph == 1)
                chk(mem_addr == m_base + 4 * m_idx, "R3", "mem_addr", mem_addr, m_base + 4 * m_idx);
            chk(seq_load == (m_ph == 4), "R4", "seq_load", seq_load, m_ph == 4);
            if (m_ph == 4)
                chk(seq_image == exp_img, "R4", "seq_image", seq_image[63:0], exp_img[63:0]);
            chk(node_addr == m_node, "R2", "node_addr", node_addr, m_node);
            chk(evt_loaded == (m_ph == 4 && m_first), "R5", "evt_loaded", evt_loaded, m_ph == 4 && m_first);
            chk(evt_cmd_done == m_done, "R6", "evt_cmd_done", evt_cmd_done, m_done);
            chk(seq_abort == m_abort, "R10", "seq_abort", seq_abort, m_abort);
            if (seq_load) n_loads++;
            if (evt_loaded) n_loaded_evt++;
            if (evt_cmd_done) n_done_evt++;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            report();
            $finish;
        end
    end

    task automatic write_head(input logic [31:0] v);
        @(negedge clk); head_we = 1'b1; head_din = v;
        @(negedge clk); head_we = 1'b0;
    endtask
    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask
    task automatic pulse_cancel();
        @(negedge clk); cancel = 1'b1;
        @(negedge clk); cancel = 1'b0;
    endtask
    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int l0, e0, d0;
        for (int k = 0; k < 512; k++) mem[k] = '0;
        put_desc(32'h040, 0, 1);
        put_desc(32'h100, 32'h200, 2);
        put_desc(32'h200, 32'h300, 3);
        put_desc(32'h300, 0, 4);
        put_desc(32'h400, 32'h480, 5);
        put_desc(32'h480, 32'h400, 6);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!busy && !mem_req && !seq_load && !seq_abort && !evt_loaded && !evt_cmd_done,
            "R1", "idle outputs", {busy, mem_req, seq_load}, 0);
        chk(node_addr == 0, "R1", "node_addr", node_addr, 0);

        // single descriptor, R7
        write_head(32'h040);
        l0 = n_loads; d0 = n_done_evt;
        pulse_start();
        wait_idle();
        chk(n_loads - l0 == 1, "R7", "single loads", n_loads - l0, 1);
        chk(n_done_evt - d0 == 1, "R7", "single done events", n_done_evt - d0, 1);

        // three-link chain with stray start / head write mid-run, R8 R12
        lat = 2;
        write_head(32'h100);
        l0 = n_loads; e0 = n_loaded_evt; d0 = n_done_evt;
        pulse_start();
        repeat (4) @(negedge clk);
        pulse_start();
        write_head(32'h040);
        wait_idle();
        chk(n_loads - l0 == 3, "R8", "chain loads", n_loads - l0, 3);
        chk(n_done_evt - d0 == 3, "R8", "chain done events", n_done_evt - d0, 3);
        chk(n_loaded_evt - e0 == 1, "R12", "start while busy ignored", n_loaded_evt - e0, 1);
        chk(node_addr == 32'h300, "R2", "node holds last descriptor", node_addr, 32'h300);

        // cyclic ring, R9 R5
        lat = 1;
        write_head(32'h400);
        l0 = n_loads; e0 = n_loaded_evt;
        pulse_start();
        while (n_loads - l0 < 6) @(negedge clk);
        chk(busy == 1'b1, "R9", "ring still busy", busy, 1);
        chk(n_loaded_evt - e0 == 1, "R5", "one loaded event per run", n_loaded_evt - e0, 1);
        pulse_cancel();
        wait_idle();

        // zero head, R12
        write_head(32'h0);
        pulse_start();
        @(negedge clk);
        chk(!busy && !mem_req, "R12", "start with zero head", busy, 0);

        // cancel with read outstanding, R11
        lat = 3;
        write_head(32'h040);
        pulse_start();
        pulse_cancel();
        chk(busy == 1'b1, "R11", "busy during flush", busy, 1);
        wait_idle();
        chk(busy == 1'b0, "R11", "idle after flush", busy, 0);

        // cancel while executing, R10
        lat = 1;
        auto_done = 1'b0;
        d0 = n_done_evt;
        pulse_start();
        while (!seq_load) @(negedge clk);
        repeat (2) @(negedge clk);
        pulse_cancel();
        chk(!busy && seq_abort, "R10", "cancel in run", {busy, seq_abort}, 1);
        repeat (3) @(negedge clk);
        chk(n_done_evt == d0, "R10", "no done after cancel", n_done_evt, d0);
        auto_done = 1'b1;

        // restart after cancel works, R3
        l0 = n_loads;
        pulse_start();
        wait_idle();
        chk(n_loads - l0 == 1, "R3", "restart after cancel", n_loads - l0, 1);

        report();
        $finish;
    end
endmodule